// File: doc/BRIEF.md
# DSP Bit-Position Control Unit

This unit keeps two small runtime control fields, a bit position and a field size, and runs the datapath operations that depend on them. A variable bitfield insert takes its lowest target bit from the position field and its width from the size field. It copies the low bits of one operand into a copy of the other operand at that position. A fixed 16-bit reversal mirrors the low half of an operand. A branch-condition flag is raised whenever the position field reaches 32 or more. A bitstream reader uses it to decide that another 32-bit word must be fetched.

The control fields are loaded through a dedicated write strobe and take effect from the next clock cycle. Result and branch flag are combinational functions of the current operands, the op select and the registered fields. The surrounding pipeline owns program-counter update and fetch.

Top module: `bitpos_ctl_unit`

## Requirements
- R1: After reset both control fields are zero, so the branch flag is low and an insert (op 2'b00) returns the destination operand unchanged.
- R2: A write with `ctl_we` high loads `ctl_pos_wr` and `ctl_size_wr` at the clock edge. Operations in the same cycle still see the old fields, and operations from the next cycle onwards see the new ones.
- R3: With op 2'b00 and valid fields, result bits pos..pos+size-1 hold bits size-1..0 of `src_a`. Every other result bit equals the same bit of `src_b`.
- R4: With op 2'b00 and a size field of zero, the result equals `src_b`.
- R5: With op 2'b00, if pos+size is greater than 32 the result equals `src_b`. A field ending exactly at bit 31 (pos+size equal to 32) is inserted normally.
- R6: With op 2'b01, result bit i equals `src_a` bit 15-i for i in 0..15, and result bits 31..16 are zero.
- R7: `branch_ge32` is high exactly when the registered position field is 32 or greater. It does not depend on the op select or the operands.
- R8: Op codes 2'b10 and 2'b11 produce a result of zero.
- R9: While `ctl_we` is low the control fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Write strobe for both control fields |
| ctl_pos_wr | input | 6 | New position field value |
| ctl_size_wr | input | 6 | New size field value |
| op_sel | input | 2 | 00 insert, 01 reverse, 10/11 spare (zero) |
| src_a | input | 32 | Insert source bits / reversal operand |
| src_b | input | 32 | Insert destination word |
| result | output | 32 | Operation result |
| branch_ge32 | output | 1 | Position field is at least 32 |

## Verification
A control write and a dependent operation can land in the same cycle, because the write strobe and the op select are independent inputs. The bench provokes this by mixing random writes into a random stream of inserts and reversals. It also drives directed cases where a write and an insert share a cycle. The expected result in such a cycle is computed from the bench's copy of the fields as they stood before the edge. The expected branch flag one cycle later is computed from the newly written position.

// File: rtl/bitpos_pkg.sv
package bitpos_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned FLD_W  = 6;
  localparam int unsigned REV_W  = 16;

  typedef enum logic [1:0] {
    OPC_INSERT = 2'b00,
    OPC_BITREV = 2'b01,
    OPC_SPARE2 = 2'b10,
    OPC_SPARE3 = 2'b11
  } bp_op_e;

  typedef struct packed {
    logic [FLD_W-1:0] pos;
    logic [FLD_W-1:0] size;
  } bp_ctl_t;
endpackage

// File: rtl/bitpos_ctl_regs.sv
module bitpos_ctl_regs
  import bitpos_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [FLD_W-1:0] pos_in,
  input  logic [FLD_W-1:0] size_in,
  output bp_ctl_t          ctl_q
);
  bp_ctl_t ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) begin
      ctl_d.pos  = pos_in;
      ctl_d.size = size_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_en) begin
      ctl_q <= ctl_d;
    end
  end
endmodule

// File: rtl/bitpos_insert_unit.sv
module bitpos_insert_unit #(
  parameter int unsigned W  = 32,
  parameter int unsigned PW = 6
) (
  input  logic [PW-1:0] pos,
  input  logic [PW-1:0] size,
  input  logic [W-1:0]  field_src,
  input  logic [W-1:0]  dest,
  output logic [W-1:0]  merged
);
  localparam int unsigned EW = PW + 1;
  localparam logic [EW-1:0] LIMIT = EW'(W);

  logic [EW-1:0] end_excl;
  logic          fits;
  logic [W-1:0]  shifted;
  logic [W-1:0]  in_field;

  assign end_excl = {1'b0, pos} + {1'b0, size};
  assign fits     = (size != '0) && (end_excl <= LIMIT);
  assign shifted  = field_src << pos;

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [EW-1:0] IDX = EW'(i);
    assign in_field[i] = ({1'b0, pos} <= IDX) && (IDX < end_excl);
    assign merged[i]   = (fits && in_field[i]) ? shifted[i] : dest[i];
  end
endmodule

// File: rtl/bitpos_reverse_unit.sv
module bitpos_reverse_unit #(
  parameter int unsigned W  = 32,
  parameter int unsigned RW = 16
) (
  input  logic [W-1:0] operand,
  output logic [W-1:0] mirrored
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < RW) begin : g_rev
      assign mirrored[i] = operand[RW-1-i];
    end else begin : g_zero
      assign mirrored[i] = 1'b0;
    end
  end
endmodule

// File: rtl/bitpos_branch_test.sv
module bitpos_branch_test #(
  parameter int unsigned PW    = 6,
  parameter int unsigned LIMIT = 32
) (
  input  logic [PW-1:0] pos,
  output logic          take
);
  localparam logic [PW-1:0] THRESH = PW'(LIMIT);
  assign take = (pos >= THRESH);
endmodule

// File: rtl/bitpos_ctl_unit.sv
module bitpos_ctl_unit
  import bitpos_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [5:0]  ctl_pos_wr,
  input  logic [5:0]  ctl_size_wr,
  input  logic [1:0]  op_sel,
  input  logic [31:0] src_a,
  input  logic [31:0] src_b,
  output logic [31:0] result,
  output logic        branch_ge32
);
  bp_ctl_t           ctl_q;
  logic [DATA_W-1:0] ins_res;
  logic [DATA_W-1:0] rev_res;
  bp_op_e            op;

  assign op = bp_op_e'(op_sel);

  bitpos_ctl_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_we),
    .pos_in  (ctl_pos_wr),
    .size_in (ctl_size_wr),
    .ctl_q   (ctl_q)
  );

  bitpos_insert_unit #(.W(DATA_W), .PW(FLD_W)) u_ins (
    .pos       (ctl_q.pos),
    .size      (ctl_q.size),
    .field_src (src_a),
    .dest      (src_b),
    .merged    (ins_res)
  );

  bitpos_reverse_unit #(.W(DATA_W), .RW(REV_W)) u_rev (
    .operand  (src_a),
    .mirrored (rev_res)
  );

  bitpos_branch_test #(.PW(FLD_W), .LIMIT(DATA_W)) u_br (
    .pos  (ctl_q.pos),
    .take (branch_ge32)
  );

  always_comb begin
    unique case (op)
      OPC_INSERT: result = ins_res;
      OPC_BITREV: result = rev_res;
      default:    result = '0;
    endcase
  end
endmodule

// File: rtl/bitpos_ctl_unit_chk.sv
module bitpos_ctl_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_we,
  input logic [5:0]  ctl_pos_wr,
  input logic [5:0]  ctl_size_wr,
  input logic [1:0]  op_sel,
  input logic [31:0] src_a,
  input logic [31:0] src_b,
  input logic [31:0] result,
  input logic        branch_ge32
);
  function automatic logic [15:0] mirror16(input logic [15:0] v);
    for (int k = 0; k < 16; k++) mirror16[k] = v[15-k];
  endfunction

  AST_WRITE_POS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (branch_ge32 == ($past(ctl_pos_wr) >= 6'd32))); // R2

  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(branch_ge32)); // R9

  AST_REV_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b01) |-> (result[31:16] == 16'h0)); // R6

  AST_REV_LOW_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b01) |-> (result[15:0] == mirror16(src_a[15:0]))); // R6

  AST_SPARE_OP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel[1] |-> (result == 32'h0)); // R8

  AST_SIZE_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_size_wr == 6'd0) |=> (op_sel != 2'b00 || result == src_b)); // R4

  AST_WIDE_FIELD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ({1'b0, ctl_pos_wr} + {1'b0, ctl_size_wr} > 7'd32))
      |=> (op_sel != 2'b00 || result == src_b)); // R5
endmodule

bind bitpos_ctl_unit bitpos_ctl_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctl_we      (ctl_we),
  .ctl_pos_wr  (ctl_pos_wr),
  .ctl_size_wr (ctl_size_wr),
  .op_sel      (op_sel),
  .src_a       (src_a),
  .src_b       (src_b),
  .result      (result),
  .branch_ge32 (branch_ge32)
);

// File: tb/bitpos_ctl_unit_test.sv
`timescale 1ns/1ps
module bitpos_ctl_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_we;
  logic [5:0]  ctl_pos_wr;
  logic [5:0]  ctl_size_wr;
  logic [1:0]  op_sel;
  logic [31:0] src_a;
  logic [31:0] src_b;
  logic [31:0] result;
  logic        branch_ge32;

  int n_run  = 0;
  int n_fail = 0;
  logic [5:0] m_pos;
  logic [5:0] m_size;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bitpos_ctl_unit uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_pos_wr(ctl_pos_wr),
    .ctl_size_wr(ctl_size_wr), .op_sel(op_sel), .src_a(src_a), .src_b(src_b),
    .result(result), .branch_ge32(branch_ge32)
  );

  function automatic logic [31:0] exp_result(input logic [1:0] op, input logic [5:0] p,
                                             input logic [5:0] s, input logic [31:0] a,
                                             input logic [31:0] b);
    logic [31:0] r;
    int endb;
    r = '0;
    endb = int'(p) + int'(s);
    case (op)
      2'b00: begin
        r = b;
        if (s != 0 && endb <= 32)
          for (int k = 0; k < int'(s); k++) r[int'(p) + k] = a[k];
      end
      2'b01: for (int k = 0; k < 16; k++) r[k] = a[15-k];
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle; outputs checked before the edge against the pre-edge fields
  task automatic step(input logic we, input logic [5:0] p, input logic [5:0] s,
                      input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                      input string req);
    @(negedge clk);
    ctl_we = we; ctl_pos_wr = p; ctl_size_wr = s; op_sel = op; src_a = a; src_b = b;
    #1;
    check(req, result, exp_result(op, m_pos, m_size, a, b));
    check("R7", {31'b0, branch_ge32}, {31'b0, m_pos >= 6'd32});
    @(posedge clk);
    if (we) begin m_pos = p; m_size = s; end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; ctl_we = 0; ctl_pos_wr = 0; ctl_size_wr = 0;
    op_sel = 0; src_a = 0; src_b = 0;
    m_pos = 0; m_size = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset fields zero
    step(0, 6'd0, 6'd0, 2'b00, 32'hFFFF_FFFF, 32'h1234_5678, "R1");
    check("R1", {31'b0, branch_ge32}, 32'd0);
    // R2: same-cycle write with insert uses old fields
    step(1, 6'd4, 6'd8, 2'b00, 32'h0000_00AB, 32'h0000_0000, "R2");
    step(0, 6'd0, 6'd0, 2'b00, 32'h0000_00AB, 32'h0000_0000, "R2");
    check("R2", result, 32'h0000_0AB0);
    // R3: insert at top end exactly fitting (R5 boundary)
    step(1, 6'd24, 6'd8, 2'b00, 32'h0, 32'h0, "R3");
    step(0, 6'd0, 6'd0, 2'b00, 32'hFFFF_FF5A, 32'h0011_2233, "R5");
    check("R5", result, 32'h5A11_2233);
    // R5: overflow by one keeps dest
    step(1, 6'd25, 6'd8, 2'b00, 32'h0, 32'h0, "R5");
    step(0, 6'd0, 6'd0, 2'b00, 32'hFFFF_FFFF, 32'hCAFE_F00D, "R5");
    check("R5", result, 32'hCAFE_F00D);
    // R4: size zero keeps dest
    step(1, 6'd3, 6'd0, 2'b00, 32'h0, 32'h0, "R4");
    step(0, 6'd9, 6'd9, 2'b00, 32'hFFFF_FFFF, 32'h0BAD_BEEF, "R4");
    check("R4", result, 32'h0BAD_BEEF);
    // R3: full-word insert
    step(1, 6'd0, 6'd32, 2'b00, 32'h0, 32'h0, "R3");
    step(0, 6'd0, 6'd0, 2'b00, 32'h8765_4321, 32'hFFFF_FFFF, "R3");
    check("R3", result, 32'h8765_4321);
    // R6: reverse
    step(0, 6'd0, 6'd0, 2'b01, 32'hFFFF_0001, 32'h0, "R6");
    check("R6", result, 32'h0000_8000);
    // R7/R9: position 32 and 31 boundary, hold without write
    step(1, 6'd32, 6'd1, 2'b10, 32'h1, 32'h1, "R8");
    step(0, 6'd0, 6'd0, 2'b11, 32'h5, 32'h7, "R8");
    check("R7", {31'b0, branch_ge32}, 32'd1);
    step(0, 6'd0, 6'd0, 2'b00, 32'h5, 32'h7, "R9");
    check("R9", {31'b0, branch_ge32}, 32'd1);
    step(1, 6'd31, 6'd1, 2'b00, 32'h1, 32'h0, "R2");
    step(0, 6'd0, 6'd0, 2'b00, 32'h1, 32'h0, "R3");
    check("R7", {31'b0, branch_ge32}, 32'd0);
    check("R3", result, 32'h8000_0000);
    // random mix
    for (int it = 0; it < 600; it++) begin
      logic we;
      logic [5:0] p, s;
      we = ($urandom % 3) == 0;
      p = 6'($urandom % 40);
      s = 6'($urandom % 34);
      step(we, p, s, 2'($urandom), $urandom, $urandom, "R3");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule